// File: doc/BRIEF.md
# Extended Opcode Execution Unit

This block executes four single-byte, operand-free instructions that sit in otherwise unused opcode slots of a small 8-bit accumulator CPU. It owns a file of four 8-bit general registers (r0 to r3) and an eight-entry circular stack of 13-bit return addresses. A surrounding core presents a fetched opcode byte together with a valid strobe. The unit executes the instruction and, one clock later, pulses either `done` or `unhandled`.

The core also uses the block for three other jobs. It pushes return addresses on a call and pops them on a return. It reads the current top of the stack combinationally, and it loads general registers through a plain write port. The four added instructions are an unsigned 8x8 multiply into the r3:r2 pair, a swap of r0 and r1, and two transfers between the r1:r0 pair and the top stack entry. Neither transfer moves the stack pointer.

Top module: `xop_unit`

## Requirements
- R1: A synchronous active-high reset clears all four registers, all eight stack entries and the stack pointer to zero, and leaves `done` and `unhandled` low.
- R2: Opcode 0x90 forms the unsigned product r0*r1. The low byte goes to r2 and the high byte to r3. r0 and r1 are unchanged.
- R3: Opcode 0x91 exchanges r0 and r1 in one step, leaving r2 and r3 unchanged.
- R4: Opcode 0x10 loads bits 7:0 of the top stack entry into r0 and bits 12:8 into r1[4:0], and writes r1[7:5] as zero.
- R5: Opcode 0x11 replaces the top stack entry with {r1[4:0], r0}, discarding r1[7:5]. Neither 0x10 nor 0x11 changes the stack pointer.
- R6: For each of the four handled opcodes, `done` is high for exactly the one cycle after the cycle in which `op_valid` was sampled high, and `unhandled` stays low.
- R7: Any other opcode leaves registers, stack and pointer unchanged and raises `unhandled` for exactly the following cycle, with `done` low.
- R8: `call_valid` increments the stack pointer and stores `call_addr` in the newly pointed entry. `ret_valid` decrements the pointer. `ret_addr` always shows the entry at the pointer.
- R9: The pointer is 3 bits wide and wraps: a push from 7 goes to 0 and overwrites entry 0, and a pop from 0 goes to 7.
- R10: While `op_valid` is high, `call_valid`, `ret_valid` and `wr_en` have no effect. When both `call_valid` and `ret_valid` are high, only the push happens.
- R11: With `op_valid` low, `wr_en` writes `wr_data` into register `wr_sel` at the clock edge. `regs_out` shows r0 in bits 7:0, r1 in 15:8, r2 in 23:16 and r3 in 31:24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode byte is present this cycle |
| op_code | input | 8 | Fetched opcode byte |
| done | output | 1 | Handled instruction finished (one-cycle pulse) |
| unhandled | output | 1 | Opcode was not one of the four (one-cycle pulse) |
| call_valid | input | 1 | Push `call_addr` on the stack |
| call_addr | input | 13 | Return address to push |
| ret_valid | input | 1 | Pop the stack |
| ret_addr | output | 13 | Entry at the stack pointer |
| stack_ptr | output | 3 | Current stack pointer |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register index to write |
| wr_data | input | 8 | Register write data |
| regs_out | output | 32 | r3:r2:r1:r0 concatenated |

## Verification
The multiply is tried with extreme operands (0, 1, 255*255) and with random byte pairs. These catch swapped product halves, truncation and signed treatment. Transfers use r1 values with bits 7:5 set and stack entries with bit 12 set, which separates correct field masking from a plain byte copy. Random mixes of calls, returns, register writes, handled opcodes and arbitrary bytes, including ones that collide with `op_valid`, run against a bench model. They expose wrong priorities, pointer drift across wraps, and side effects of unrecognised opcodes.

// File: rtl/xop_pkg.sv
package xop_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 13;
    localparam int NREGS     = 4;
    localparam int STK_DEPTH = 8;
    localparam int SEL_W     = $clog2(NREGS);
    localparam int SP_W      = $clog2(STK_DEPTH);
    localparam int HI_BITS   = ADDR_W - DATA_W;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam byte_t OPC_MUL     = 8'h90;
    localparam byte_t OPC_SWAP    = 8'h91;
    localparam byte_t OPC_TOP2REG = 8'h10;
    localparam byte_t OPC_REG2TOP = 8'h11;

    typedef enum logic [2:0] {
        K_IDLE,
        K_MUL,
        K_SWAP,
        K_TOP2REG,
        K_REG2TOP,
        K_BAD
    } op_kind_t;

    function automatic op_kind_t classify(input logic v, input byte_t c);
        op_kind_t k;
        if (!v)                    k = K_IDLE;
        else if (c == OPC_MUL)     k = K_MUL;
        else if (c == OPC_SWAP)    k = K_SWAP;
        else if (c == OPC_TOP2REG) k = K_TOP2REG;
        else if (c == OPC_REG2TOP) k = K_REG2TOP;
        else                       k = K_BAD;
        return k;
    endfunction

    function automatic logic is_known(input byte_t c);
        return (c == OPC_MUL) || (c == OPC_SWAP) ||
               (c == OPC_TOP2REG) || (c == OPC_REG2TOP);
    endfunction

    function automatic addr_t join_addr(input byte_t lo, input byte_t hi);
        return {hi[HI_BITS-1:0], lo};
    endfunction

endpackage

// File: rtl/xop_decode.sv
module xop_decode
    import xop_pkg::*;
(
    input  logic     valid,
    input  byte_t    code,
    output op_kind_t kind
);
    always_comb kind = classify(valid, code);
endmodule

// File: rtl/xop_stack.sv
module xop_stack
    import xop_pkg::*;
#(
    parameter int DEPTH = STK_DEPTH,
    parameter int AW    = ADDR_W,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_addr,
    input  logic          top_we,
    input  logic [AW-1:0] top_wdata,
    output logic [AW-1:0] top,
    output logic [PW-1:0] sp
);
    localparam logic [PW-1:0] ONE = PW'(1);

    logic [DEPTH-1:0][AW-1:0] mem;
    logic [PW-1:0]            ptr;
    logic [PW-1:0]            ptr_up;
    logic [PW-1:0]            ptr_dn;

    // pointer arithmetic wraps modulo DEPTH (DEPTH is a power of two)
    assign ptr_up = ptr + ONE;
    assign ptr_dn = ptr - ONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
            ptr <= '0;
        end else if (push) begin
            mem[ptr_up] <= push_addr;
            ptr         <= ptr_up;
        end else if (pop) begin
            ptr <= ptr_dn;
        end else if (top_we) begin
            mem[ptr] <= top_wdata;
        end
    end

    assign top = mem[ptr];
    assign sp  = ptr;

    a_r8_push_step: assert property (@(posedge clk) disable iff (rst)
        push |=> (sp == PW'($past(sp) + 1)) && (top == $past(push_addr)));
    a_r9_pop_wrap: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> sp == PW'($past(sp) - 1));
    a_r5_top_write: assert property (@(posedge clk) disable iff (rst)
        (top_we && !push && !pop) |=> (top == $past(top_wdata)) && $stable(sp));

endmodule

// File: rtl/xop_regfile.sv
module xop_regfile
    import xop_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int NR = NREGS,
    localparam int SW = $clog2(NR)
) (
    input  logic                clk,
    input  logic                rst,
    input  op_kind_t            kind,
    input  logic [AW-1:0]       top,
    input  logic                wr_en,
    input  logic [SW-1:0]       wr_sel,
    input  logic [DW-1:0]       wr_data,
    output logic [NR-1:0][DW-1:0] regs
);
    logic [2*DW-1:0] prod;

    assign prod = (2*DW)'(regs[0]) * (2*DW)'(regs[1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            unique case (kind)
                K_MUL: begin
                    regs[2] <= prod[DW-1:0];
                    regs[3] <= prod[2*DW-1:DW];
                end
                K_SWAP: begin
                    regs[0] <= regs[1];
                    regs[1] <= regs[0];
                end
                K_TOP2REG: begin
                    regs[0] <= top[DW-1:0];
                    regs[1] <= DW'(top[AW-1:DW]);
                end
                K_REG2TOP, K_BAD: ;
                default: begin
                    if (wr_en) regs[wr_sel] <= wr_data;
                end
            endcase
        end
    end

    a_r2_product: assert property (@(posedge clk) disable iff (rst)
        (kind == K_MUL) |=> ({regs[3], regs[2]} == $past(regs[0]) * $past(regs[1]))
                            && $stable(regs[0]) && $stable(regs[1]));
    a_r3_exchange: assert property (@(posedge clk) disable iff (rst)
        (kind == K_SWAP) |=> (regs[0] == $past(regs[1])) && (regs[1] == $past(regs[0])));
    a_r4_high_clear: assert property (@(posedge clk) disable iff (rst)
        (kind == K_TOP2REG) |=> regs[1][DW-1:AW-DW] == '0);
    a_r7_no_change: assert property (@(posedge clk) disable iff (rst)
        (kind == K_BAD) |=> $stable(regs));

endmodule

// File: rtl/xop_unit.sv
module xop_unit
    import xop_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    op_valid,
    input  logic [DATA_W-1:0]       op_code,
    output logic                    done,
    output logic                    unhandled,
    input  logic                    call_valid,
    input  logic [ADDR_W-1:0]       call_addr,
    input  logic                    ret_valid,
    output logic [ADDR_W-1:0]       ret_addr,
    output logic [SP_W-1:0]         stack_ptr,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [NREGS*DATA_W-1:0] regs_out
);
    op_kind_t                       kind;
    logic [NREGS-1:0][DATA_W-1:0]   regs;
    addr_t                          top;
    logic                           push;
    logic                           pop;

    xop_decode u_dec (
        .valid (op_valid),
        .code  (op_code),
        .kind  (kind)
    );

    // instruction strobe blocks the side ports; push beats pop
    assign push = !op_valid && call_valid;
    assign pop  = !op_valid && !call_valid && ret_valid;

    xop_stack #(.DEPTH(STK_DEPTH), .AW(ADDR_W)) u_stk (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .pop       (pop),
        .push_addr (call_addr),
        .top_we    (kind == K_REG2TOP),
        .top_wdata (join_addr(regs[0], regs[1])),
        .top       (top),
        .sp        (stack_ptr)
    );

    xop_regfile #(.DW(DATA_W), .AW(ADDR_W), .NR(NREGS)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .kind    (kind),
        .top     (top),
        .wr_en   (wr_en && !op_valid),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .regs    (regs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            unhandled <= 1'b0;
        end else begin
            done      <= (kind != K_IDLE) && (kind != K_BAD);
            unhandled <= (kind == K_BAD);
        end
    end

    assign ret_addr = top;
    assign regs_out = regs;

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        (op_valid && is_known(op_code)) |=> done && !unhandled);
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !done && !unhandled);
    a_r7_flag: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !is_known(op_code)) |=> unhandled && !done);
    a_r10_sp_hold: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> $stable(stack_ptr));
    a_r1_flags_excl: assert property (@(posedge clk) disable iff (rst)
        !(done && unhandled));

endmodule

// File: tb/xop_unit_test.sv
module xop_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [7:0]  op_code = '0;
    logic        done, unhandled;
    logic        call_valid = 1'b0;
    logic [12:0] call_addr = '0;
    logic        ret_valid = 1'b0;
    logic [12:0] ret_addr;
    logic [2:0]  stack_ptr;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [31:0] regs_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    logic [7:0]  m_r [4];
    logic [12:0] m_s [8];
    logic [2:0]  m_sp;
    logic        m_done, m_unh;

    always #10 clk = ~clk;

    xop_unit uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .done(done), .unhandled(unhandled), .call_valid(call_valid),
        .call_addr(call_addr), .ret_valid(ret_valid), .ret_addr(ret_addr),
        .stack_ptr(stack_ptr), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .regs_out(regs_out)
    );

    function automatic bit known(input logic [7:0] c);
        return c == 8'h90 || c == 8'h91 || c == 8'h10 || c == 8'h11;
    endfunction

    function automatic logic [31:0] model_regs();
        return {m_r[3], m_r[2], m_r[1], m_r[0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_r[i] = '0;
        for (int i = 0; i < 8; i++) m_s[i] = '0;
        m_sp = '0; m_done = 0; m_unh = 0;
    endtask

    // update the bench model as required by R2..R11
    task automatic model_step(input bit ov, input logic [7:0] oc, input bit cv,
                              input logic [12:0] ca, input bit rv, input bit we,
                              input logic [1:0] ws, input logic [7:0] wd);
        logic [15:0] p;
        m_done = ov && known(oc);
        m_unh  = ov && !known(oc);
        if (ov) begin
            case (oc)
                8'h90: begin p = 16'(m_r[0]) * 16'(m_r[1]); m_r[2] = p[7:0]; m_r[3] = p[15:8]; end
                8'h91: begin m_r[0] = m_r[1]; m_r[1] = m_r[0] ^ m_r[1] ^ m_r[0]; end
                8'h10: begin m_r[0] = m_s[m_sp][7:0]; m_r[1] = {3'b000, m_s[m_sp][12:8]}; end
                8'h11: m_s[m_sp] = {m_r[1][4:0], m_r[0]};
                default: ;
            endcase
        end else begin
            if (cv) begin m_sp = m_sp + 3'd1; m_s[m_sp] = ca; end
            else if (rv) m_sp = m_sp - 3'd1;
            if (we) m_r[ws] = wd;
        end
    endtask

    task automatic step(input string req, input bit ov, input logic [7:0] oc,
                        input bit cv, input logic [12:0] ca, input bit rv,
                        input bit we, input logic [1:0] ws, input logic [7:0] wd);
        logic [7:0] old_r0;
        old_r0 = m_r[0];
        op_valid = ov; op_code = oc; call_valid = cv; call_addr = ca;
        ret_valid = rv; wr_en = we; wr_sel = ws; wr_data = wd;
        if (ov && oc == 8'h91) begin
            model_step(ov, oc, cv, ca, rv, we, ws, wd);
            m_r[1] = old_r0;
        end else begin
            model_step(ov, oc, cv, ca, rv, we, ws, wd);
        end
        @(negedge clk);
        op_valid = 0; call_valid = 0; ret_valid = 0; wr_en = 0;
        check({req, " regs"}, regs_out, model_regs());
        check({req, " sp"}, 32'(stack_ptr), 32'(m_sp));
        check({req, " top"}, 32'(ret_addr), 32'(m_s[m_sp]));
        check({req, " done"}, 32'(done), 32'(m_done));
        check({req, " unhandled"}, 32'(unhandled), 32'(m_unh));
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        step("R11", 0, 8'h00, 0, 13'h0, 0, 1, s, d);
    endtask

    task automatic op(input string req, input logic [7:0] c);
        step(req, 1, c, 0, 13'h0, 0, 0, 2'd0, 8'h00);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        check("R1 regs", regs_out, 32'h0);
        check("R1 sp", 32'(stack_ptr), 32'h0);
        check("R1 top", 32'(ret_addr), 32'h0);
        check("R1 flags", {30'h0, done, unhandled}, 32'h0);

        // R2: multiply corners
        wr(2'd0, 8'hFF); wr(2'd1, 8'hFF); op("R2 255*255", 8'h90);
        check("R2 product", {16'h0, regs_out[31:16]}, 32'hFE01);
        wr(2'd0, 8'h00); op("R2 0*x", 8'h90);
        wr(2'd0, 8'h01); wr(2'd1, 8'hA7); op("R2 1*x", 8'h90);
        // R3: swap
        op("R3 swap", 8'h91);
        // R6: done only for one cycle
        step("R6 idle after", 0, 8'h90, 0, 13'h0, 0, 0, 2'd0, 8'h00);
        // R8 / R9: push nine times, wrapping onto entry 0
        for (int i = 0; i < 9; i++) step("R9 push", 0, 8'h00, 1, 13'(13'h1000 + i), 0, 0, 2'd0, 8'h00);
        check("R9 wrap sp", 32'(stack_ptr), 32'd1);
        for (int i = 0; i < 2; i++) step("R9 pop", 0, 8'h00, 0, 13'h0, 1, 0, 2'd0, 8'h00);
        check("R9 underflow sp", 32'(stack_ptr), 32'd7);
        // R4: top with bit 12 set into regs, r1 upper bits cleared
        wr(2'd1, 8'hFF); op("R4 top to regs", 8'h10);
        // R5: regs to top drops r1[7:5]
        wr(2'd0, 8'h5A); wr(2'd1, 8'hE3); op("R5 regs to top", 8'h11);
        check("R5 entry", 32'(ret_addr), 32'h035A);
        // R7: unhandled opcode
        op("R7 bad 0x92", 8'h92);
        op("R7 bad 0x00", 8'h00);
        // R10: side ports blocked by op_valid; call beats ret
        step("R10 blocked", 1, 8'h91, 1, 13'h1ABC, 1, 1, 2'd3, 8'h77);
        step("R10 call over ret", 0, 8'h00, 1, 13'h0ABC, 1, 0, 2'd0, 8'h00);

        // mixed random traffic
        void'($urandom(32'd2650));
        for (int i = 0; i < 1500; i++) begin
            int sel;
            logic [7:0] c;
            sel = int'($urandom % 10);
            case ($urandom % 4)
                0: c = 8'h90; 1: c = 8'h91; 2: c = 8'h10; default: c = 8'h11;
            endcase
            if ($urandom % 4 == 0) c = 8'($urandom);
            if (sel < 4)
                step("R2-mix", 1, c, ($urandom % 4) == 0, 13'($urandom), ($urandom % 4) == 0,
                     ($urandom % 3) == 0, 2'($urandom), 8'($urandom));
            else
                step("R8-mix", 0, c, ($urandom % 3) == 0, 13'($urandom), ($urandom % 3) == 0,
                     ($urandom % 2) == 0, 2'($urandom), 8'($urandom));
        end

        // reset mid-run clears everything (R1)
        rst = 1; model_reset();
        @(negedge clk); rst = 0;
        check("R1 re-reset regs", regs_out, 32'h0);
        check("R1 re-reset sp", 32'(stack_ptr), 32'h0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule